// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a two-wire serial bus slave that exposes a small bank of byte-wide registers to an external bus master. The bus lines are oversampled by the system clock. The block recognises bus start and stop events and its own 7-bit device address with a direction bit. After the device address it takes a register subaddress and then moves data bytes into or out of the bank. An internal pointer advances after every data byte, so a master can stream through neighbouring registers without sending the subaddress again.

The output `sda_oe` is an open-drain enable. When it is 1, the pad pulls the data line low. When it is 0, the line is released. The slave asserts it only to acknowledge a byte or to send a 0 bit of read data. The register contents appear in parallel on `cfg_o` for the surrounding logic. The highest valid subaddress is a status register. Reads of it return the `status_i` input, and writes to it are discarded.

Top module: `i2c_reg_slave`

## Requirements
- R1: After synchronous reset, `sda_oe` is 0, every byte of `cfg_o` is 0, and the subaddress pointer is 0.
- R2: A first byte whose upper seven bits equal DEV_ADDR (default 0x42) is acknowledged on the ninth clock. Its bit 0 selects write (0) or read (1). Any other address gets no acknowledge, and the slave acknowledges nothing more until the next start.
- R3: In a write, the byte after the device address is the subaddress. Values 0 to MAX_SUB (default 5) are acknowledged and loaded into the pointer. A larger value gets no acknowledge, the slave goes idle, and later data bytes are neither acknowledged nor stored.
- R4: The sequence start, write address, subaddress, one data byte, stop updates only that one register, which appears at `cfg_o[8*sub +: 8]`.
- R5: In a write, every further data byte goes to the next subaddress in turn. The pointer saturates at MAX_SUB.
- R6: A read begins at the current pointer and sends each byte most significant bit first. The pointer advances after each byte. Setting the pointer with a write phase and then issuing a repeated start gives random access.
- R7: Subaddress STAT_SUB (default 5) is read-only. A write to it is acknowledged but leaves the register unchanged. A read of it returns `status_i`.
- R8: A read that runs past MAX_SUB keeps returning the STAT_SUB register for every further byte.
- R9: When the master leaves SDATA high on the ninth clock of a read byte, the slave releases the line. It drives nothing on any later clock until a new start.
- R10: A stop at any bit position sends the slave to idle with the line released. A partially received byte is discarded.
- R11: A start at any bit position abandons the current byte and begins a new device-address phase.
- R12: A stop followed by a start within one SCK high period ends the current transfer and begins a new one, which is then served normally.
- R13: The slave starts pulling SDATA low only while SCK is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| status_i | input | 8 | Value returned by reads of the read-only status register |
| sda_oe | output | 1 | Pull SDATA low when 1, release when 0 |
| cfg_o | output | NUM_REGS*8 | Register bank contents, register n in bits 8n+7:8n |

## Verification
Bus events and clock edges come from the same synchronised samples. A stop, a start and the bit sampling of an SCK high period can therefore all fall into one high phase. The bench provokes this by raising and then lowering SDATA inside a single high period right after a write. A second case restarts in the middle of a data byte. In both cases the cycle is judged good only if the earlier transfer leaves no partial write behind and the following device address is acknowledged and its data stored.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_MACK
    } bus_state_e;

    // Decoded bus activity for one system clock cycle
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    typedef struct packed {
        logic       en;
        logic [7:0] idx;
        logic [7:0] data;
    } wr_req_t;

    // Pointer advance that holds at the top of the map
    function automatic logic [7:0] ptr_step(input logic [7:0] p, input logic [7:0] top);
        return (p >= top) ? p : p + 8'd1;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_reg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= synced;
    end

    // index 1 is SCK, index 0 is SDATA
    always_comb begin
        evt.scl      = synced[1];
        evt.sda      = synced[0];
        evt.scl_rise = synced[1] & ~prev[1];
        evt.scl_fall = ~synced[1] & prev[1];
        evt.start    = synced[1] & prev[1] & prev[0] & ~synced[0];
        evt.stop     = synced[1] & prev[1] & ~prev[0] & synced[0];
    end

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_reg_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int MAX_SUB  = 5,
    parameter int STAT_SUB = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  wr_req_t               wr,
    input  logic [7:0]            rd_idx,
    input  logic [7:0]            status_i,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic [7:0] mem [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else if (wr.en) begin
            for (int i = 0; i < NUM_REGS; i++)
                if (wr.idx == 8'(i) && i != STAT_SUB) mem[i] <= wr.data;
        end
    end

    always_comb begin
        if (rd_idx == 8'(STAT_SUB))            rd_data = status_i;
        else if (rd_idx < 8'(NUM_REGS))        rd_data = mem[rd_idx[IDX_W-1:0]];
        else                                   rd_data = '0;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
        assign cfg_o[g*8 +: 8] = mem[g];
    end

    // R3: the protocol engine never requests a store outside the valid map
    p_wr_in_map_r3: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (wr.idx <= 8'(MAX_SUB)));

endmodule

// File: rtl/i2c_reg_fsm.sv
module i2c_reg_fsm
    import i2c_reg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h42,
    parameter int         MAX_SUB  = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_evt_t   evt,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_idx,
    output wr_req_t    wr,
    output logic       sda_oe
);
    localparam logic [7:0] TOP = 8'(MAX_SUB);

    bus_state_e state;
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic [7:0] obyte;
    logic [7:0] ptr;
    logic       rw;
    logic       nack;

    assign rd_idx = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            obyte  <= '0;
            ptr    <= '0;
            rw     <= 1'b0;
            nack   <= 1'b1;
            sda_oe <= 1'b0;
            wr     <= '0;
        end else begin
            wr.en <= 1'b0;
            if (evt.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (evt.start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (evt.scl_rise) begin
                case (state)
                    ST_ADDR, ST_SUB, ST_WR:
                        if (cnt < 4'd8) begin
                            shreg <= {shreg[6:0], evt.sda};
                            cnt   <= cnt + 4'd1;
                        end
                    ST_RD_MACK: nack <= evt.sda;
                    default: ;
                endcase
            end else if (evt.scl_fall) begin
                case (state)
                    ST_ADDR:
                        if (cnt == 4'd8) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                rw     <= shreg[0];
                                sda_oe <= 1'b1;
                                state  <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    ST_ADDR_ACK:
                        if (rw) begin
                            obyte  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            cnt    <= 4'd1;
                            state  <= ST_RD;
                        end else begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            state  <= ST_SUB;
                        end
                    ST_SUB:
                        if (cnt == 4'd8) begin
                            if (shreg <= TOP) begin
                                ptr    <= shreg;
                                sda_oe <= 1'b1;
                                state  <= ST_SUB_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    ST_SUB_ACK: begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= ST_WR;
                    end
                    ST_WR:
                        if (cnt == 4'd8) begin
                            wr     <= '{en: 1'b1, idx: ptr, data: shreg};
                            sda_oe <= 1'b1;
                            state  <= ST_WR_ACK;
                        end
                    ST_WR_ACK: begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        ptr    <= ptr_step(ptr, TOP);
                        state  <= ST_WR;
                    end
                    ST_RD:
                        if (cnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr_step(ptr, TOP);
                            state  <= ST_RD_MACK;
                        end else begin
                            sda_oe <= ~obyte[6];
                            obyte  <= {obyte[6:0], 1'b0};
                            cnt    <= cnt + 4'd1;
                        end
                    ST_RD_MACK:
                        if (nack) begin
                            state <= ST_IDLE;
                        end else begin
                            obyte  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            cnt    <= 4'd1;
                            state  <= ST_RD;
                        end
                    default: ;
                endcase
            end
        end
    end

    // R10: a stop always leaves the slave idle with the line released
    p_stop_idle_r10: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (state == ST_IDLE && !sda_oe));

    // R11: a start always opens a fresh address phase
    p_start_addr_r11: assert property (@(posedge clk) disable iff (rst)
        (evt.start && !evt.stop) |=> (state == ST_ADDR && cnt == 4'd0));

    // R13: the slave begins pulling the line only while SCK is low
    p_oe_scl_low_r13: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !evt.scl);

    // R8: the pointer never leaves the valid map
    p_ptr_top_r8: assert property (@(posedge clk) disable iff (rst)
        ptr <= TOP);

    // R9: a no-acknowledge from the master ends the read with the line free
    p_nack_release_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_MACK && evt.scl_fall && nack && !evt.start && !evt.stop)
        |=> (state == ST_IDLE && !sda_oe));

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
    import i2c_reg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h42,
    parameter int         NUM_REGS = 8,
    parameter int         MAX_SUB  = 5,
    parameter int         STAT_SUB = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic [7:0]            status_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    bus_evt_t   evt;
    wr_req_t    wr;
    logic [7:0] rd_idx;
    logic [7:0] rd_data;

    i2c_line_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2c_reg_fsm #(.DEV_ADDR(DEV_ADDR), .MAX_SUB(MAX_SUB)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .rd_data (rd_data),
        .rd_idx  (rd_idx),
        .wr      (wr),
        .sda_oe  (sda_oe)
    );

    i2c_reg_bank #(.NUM_REGS(NUM_REGS), .MAX_SUB(MAX_SUB), .STAT_SUB(STAT_SUB)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .rd_idx   (rd_idx),
        .status_i (status_i),
        .rd_data  (rd_data),
        .cfg_o    (cfg_o)
    );

endmodule

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
    localparam int         Q    = 8;
    localparam logic [6:0] DEV  = 7'h42;
    localparam int         NREG = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic               rst;
    logic               scl_m;
    logic               sda_m;
    logic [7:0]         status;
    logic               sda_oe;
    logic [NREG*8-1:0]  cfg;
    logic               sda_line;

    assign sda_line = sda_oe ? 1'b0 : sda_m;

    i2c_reg_slave i_i2c_reg_slave (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .status_i (status),
        .sda_oe   (sda_oe),
        .cfg_o    (cfg)
    );

    int n_chk = 0;
    int n_bad = 0;
    int oe_hi_viol = 0;
    logic oe_q = 1'b0;
    logic [7:0] model [NREG];

    // R13 monitor: the slave must not begin driving while SCK is high
    always @(negedge clk) begin
        if (!rst && sda_oe && !oe_q && scl_m) oe_hi_viol++;
        oe_q <= sda_oe;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        scl_m = 0; hq(); sda_m = 1; hq(); scl_m = 1; hq(); sda_m = 0; hq();
    endtask

    task automatic bus_stop();
        scl_m = 0; hq(); sda_m = 0; hq(); scl_m = 1; hq(); sda_m = 1; hq();
    endtask

    task automatic bus_stop_start();
        scl_m = 0; hq(); sda_m = 0; hq(); scl_m = 1; hq(); sda_m = 1; hq(); sda_m = 0; hq();
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            scl_m = 0; hq(); sda_m = v[i]; hq(); scl_m = 1; hq(); hq();
        end
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        send_bits(v, 8);
        scl_m = 0; hq(); sda_m = 1; hq(); scl_m = 1; hq();
        ack = (sda_line == 1'b0);
        hq();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            scl_m = 0; hq(); sda_m = 1; hq(); scl_m = 1; hq();
            d[i] = sda_line;
            hq();
        end
        scl_m = 0; hq(); sda_m = give_ack ? 1'b0 : 1'b1; hq(); scl_m = 1; hq(); hq();
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < NREG; i++) check(req, cfg[i*8 +: 8], model[i]);
    endtask

    // Start, write address, subaddress; both acks expected
    task automatic open_write(input logic [7:0] sub, input string req);
        logic a;
        bus_start();
        send_byte({DEV, 1'b0}, a); check({req, " addr ack"}, a, 1'b1);
        send_byte(sub, a);         check({req, " sub ack"}, a, 1'b1);
    endtask

    task automatic open_read(input logic [7:0] sub, input string req);
        logic a;
        open_write(sub, req);
        bus_start();
        send_byte({DEV, 1'b1}, a); check({req, " read addr ack"}, a, 1'b1);
    endtask

    task automatic t_reset();
        check("R1 oe", sda_oe, 1'b0);
        check("R1 bank", cfg, '0);
    endtask

    task automatic t_single_write();
        logic a;
        open_write(8'd2, "R4");
        send_byte(8'hA5, a); check("R4 data ack", a, 1'b1);
        bus_stop();
        model[2] = 8'hA5;
        check_bank("R4");
        open_write(8'd4, "R4");
        send_byte(8'h5A, a); check("R4 data ack", a, 1'b1);
        bus_stop();
        model[4] = 8'h5A;
        check_bank("R4");
    endtask

    task automatic t_burst_write();
        logic a;
        logic [7:0] v [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
        open_write(8'd0, "R5");
        for (int i = 0; i < 4; i++) begin
            send_byte(v[i], a); check("R5 data ack", a, 1'b1);
            model[i] = v[i];
        end
        bus_stop();
        check_bank("R5");
    endtask

    task automatic t_burst_read();
        logic [7:0] d;
        open_read(8'd0, "R6");
        for (int i = 0; i < 4; i++) begin
            recv_byte(i < 3, d);
            check("R6 read data", d, model[i]);
        end
        bus_stop();
        check("R6 released", sda_oe, 1'b0);
    endtask

    task automatic t_status();
        logic a;
        logic [7:0] d;
        status = 8'h9C;
        open_write(8'd5, "R7");
        send_byte(8'hFF, a); check("R7 write ack", a, 1'b1);
        bus_stop();
        check_bank("R7");
        open_read(8'd5, "R7");
        recv_byte(1'b0, d); check("R7 status read", d, 8'h9C);
        bus_stop();
    endtask

    task automatic t_past_top();
        logic [7:0] d;
        open_read(8'd4, "R8");
        recv_byte(1'b1, d); check("R8 byte 4", d, model[4]);
        for (int i = 0; i < 3; i++) begin
            recv_byte(i < 2, d); check("R8 held top", d, 8'h9C);
        end
        bus_stop();
    endtask

    task automatic t_nack();
        logic [7:0] d;
        int low_seen = 0;
        open_read(8'd1, "R9");
        recv_byte(1'b0, d); check("R9 data", d, model[1]);
        for (int i = 0; i < 9; i++) begin
            scl_m = 0; hq(); sda_m = 1; hq(); scl_m = 1; hq();
            if (sda_line == 1'b0) low_seen++;
            hq();
        end
        check("R9 no drive after nack", low_seen, 0);
        bus_stop();
    endtask

    task automatic t_bad_sub();
        logic a;
        bus_start();
        send_byte({DEV, 1'b0}, a); check("R3 addr ack", a, 1'b1);
        send_byte(8'd7, a);        check("R3 bad sub nack", a, 1'b0);
        send_byte(8'hEE, a);       check("R3 data after bad sub", a, 1'b0);
        bus_stop();
        check_bank("R3");
    endtask

    task automatic t_bad_addr();
        logic a;
        bus_start();
        send_byte({DEV ^ 7'h01, 1'b0}, a); check("R2 wrong addr nack", a, 1'b0);
        send_byte(8'd1, a);                check("R2 ignored after mismatch", a, 1'b0);
        bus_stop();
        check_bank("R2");
    endtask

    task automatic t_stop_mid();
        open_write(8'd1, "R10");
        send_bits(8'hA0, 4);
        bus_stop();
        check("R10 released", sda_oe, 1'b0);
        check_bank("R10");
    endtask

    task automatic t_start_mid();
        logic a;
        open_write(8'd0, "R11");
        send_bits(8'hFF, 3);
        bus_start();
        send_byte({DEV, 1'b0}, a); check("R11 addr ack after restart", a, 1'b1);
        send_byte(8'd0, a);        check("R11 sub ack", a, 1'b1);
        send_byte(8'h3C, a);       check("R11 data ack", a, 1'b1);
        bus_stop();
        model[0] = 8'h3C;
        check_bank("R11");
    endtask

    task automatic t_stop_start();
        logic a;
        open_write(8'd3, "R12");
        send_byte(8'h66, a); check("R12 first data ack", a, 1'b1);
        model[3] = 8'h66;
        bus_stop_start();
        send_byte({DEV, 1'b0}, a); check("R12 addr ack", a, 1'b1);
        send_byte(8'd3, a);        check("R12 sub ack", a, 1'b1);
        send_byte(8'h99, a);       check("R12 second data ack", a, 1'b1);
        bus_stop();
        model[3] = 8'h99;
        check_bank("R12");
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1; scl_m = 1; sda_m = 1; status = 8'h00;
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 0;
        hq();
        t_reset();
        t_single_write();
        t_burst_write();
        t_burst_read();
        t_status();
        t_past_top();
        t_nack();
        t_bad_sub();
        t_bad_addr();
        t_stop_mid();
        t_start_mid();
        t_stop_start();
        check("R13 drive begins only with SCK low", oe_hi_viol, 0);
        finish_run();
    end

endmodule